// File: doc/BRIEF.md
# Separator-Framed Byte Stream Decoder

This block sits between a UART receiver and a receive DMA channel. Its input is a raw byte stream in which each frame is wrapped in separator characters. Payload bytes that would be mistaken for control characters are sent as two-byte escape sequences. The block removes the separators and treats a run of repeated separators as a single frame boundary. It turns each escape sequence back into the byte it stands for. The payload goes out on a valid/ready stream, and the last byte of each frame is marked with an end flag.

The decoder holds one payload byte back until the next input byte is accepted. It can only decide whether a byte ends a frame once it has seen the byte that follows. When a frame closes cleanly, a single-cycle completion pulse is raised together with the flagged final byte. Malformed escape sequences raise a single-cycle error pulse. The separator, the escape character and both escape code bytes are configuration inputs. They are meant to be held stable while a frame is in flight.

Top module: `sep_frame_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid_o`, `frame_done_o` and `proto_err_o` are 0 and `in_ready_o` is 1.
- R2: A raw separator byte (`cfg_sep_i`) received outside an escape sequence never appears on the output stream.
- R3: Any run of one or more consecutive separators is one boundary. A boundary with no payload byte before it produces no output and no completion pulse.
- R4: The escape byte (`cfg_esc_i`) followed by `cfg_esc_sep_i` produces one output byte equal to `cfg_sep_i`.
- R5: The escape byte followed by `cfg_esc_esc_i` produces one output byte equal to `cfg_esc_i`.
- R6: The last payload byte before a closing separator is output with `out_last_o` = 1, and every other payload byte with `out_last_o` = 0. A payload byte becomes valid in the cycle after the next input byte is accepted.
- R7: `frame_done_o` is high for exactly one cycle per closed frame. That cycle is the cycle in which the flagged final byte is first valid.
- R8: The escape byte followed by any byte other than the separator or one of the two escape codes raises `proto_err_o` for one cycle and discards both bytes. The frame continues with the next byte.
- R9: A separator right after an escape byte raises `proto_err_o`, discards the held byte and closes nothing: no completion pulse occurs. The next byte starts a new frame.
- R10: Decoding follows the current values of all four configuration inputs.
- R11: While `out_valid_o` = 1 and `out_ready_i` = 0, `in_ready_o` is 0 and `out_data_o`/`out_last_o` stay unchanged.
- R12: Payload bytes come out in input order, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_sep_i | input | 8 | Separator character |
| cfg_esc_i | input | 8 | Escape character |
| cfg_esc_sep_i | input | 8 | Second escape byte that stands for the separator |
| cfg_esc_esc_i | input | 8 | Second escape byte that stands for the escape character |
| in_valid_i | input | 1 | Raw byte valid |
| in_data_i | input | 8 | Raw byte from the UART receiver |
| in_ready_o | output | 1 | Decoder can accept a raw byte |
| out_valid_o | output | 1 | Payload byte valid |
| out_data_o | output | 8 | Payload byte |
| out_last_o | output | 1 | Payload byte is the last of its frame |
| out_ready_i | input | 1 | Downstream accepts the payload byte |
| frame_done_o | output | 1 | One-cycle pulse: frame closed cleanly |
| proto_err_o | output | 1 | One-cycle pulse: malformed escape sequence |

## Verification
The closing separator triggers two things on one clock edge: the held byte is released with its end flag, and the completion pulse is raised. The bench checks on every closed frame that both appear in the same sampled cycle. It drives the closing separator during random output stalls, so that the release of the held byte coincides with the downstream backpressure. Exhaustive sweeps over all 256 byte values, under two different configurations, force escape decoding and final-byte flagging into the same frame. Each frame is judged against an encoder model kept in the bench.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  // Decoder position relative to an escape sequence.
  typedef enum logic {
    ST_PLAIN = 1'b0,
    ST_ESC   = 1'b1
  } dec_state_e;

  // Match flags of one raw byte against the four configured characters.
  typedef struct packed {
    logic is_sep;
    logic is_esc;
    logic is_code_sep;
    logic is_code_esc;
  } byte_cls_t;

  localparam int unsigned NUM_CFG_CHARS = 4;

endpackage

// File: rtl/sfd_classify.sv
module sfd_classify
  import sfd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] raw_i,
  input  logic [DW-1:0] sep_i,
  input  logic [DW-1:0] esc_i,
  input  logic [DW-1:0] code_sep_i,
  input  logic [DW-1:0] code_esc_i,
  output byte_cls_t     cls_o
);

  logic [DW-1:0] ref_chars [NUM_CFG_CHARS];
  logic [NUM_CFG_CHARS-1:0] hit;

  assign ref_chars[0] = sep_i;
  assign ref_chars[1] = esc_i;
  assign ref_chars[2] = code_sep_i;
  assign ref_chars[3] = code_esc_i;

  for (genvar g = 0; g < NUM_CFG_CHARS; g++) begin : g_cmp
    assign hit[g] = (raw_i == ref_chars[g]);
  end

  assign cls_o.is_sep      = hit[0];
  assign cls_o.is_esc      = hit[1];
  assign cls_o.is_code_sep = hit[2];
  assign cls_o.is_code_esc = hit[3];

endmodule

// File: rtl/sfd_core.sv
module sfd_core
  import sfd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [DW-1:0] raw_i,
  input  byte_cls_t     cls_i,
  input  logic [DW-1:0] sep_i,
  input  logic [DW-1:0] esc_i,
  output logic          emit_o,
  output logic [DW-1:0] emit_data_o,
  output logic          emit_last_o,
  output logic          done_o,
  output logic          err_o
);

  dec_state_e    st_q, st_d;
  logic          hold_vld_q, hold_vld_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          hold_en;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          push;
  logic [DW-1:0] decoded;

  // Next-state logic
  always_comb begin
    st_d        = st_q;
    hold_vld_d  = hold_vld_q;
    hold_d      = hold_q;
    hold_en     = 1'b0;
    done_d      = 1'b0;
    err_d       = 1'b0;
    push        = 1'b0;
    decoded     = raw_i;
    emit_o      = 1'b0;
    emit_data_o = hold_q;
    emit_last_o = 1'b0;

    if (fire_i) begin
      unique case (st_q)
        ST_PLAIN: begin
          if (cls_i.is_sep) begin
            // boundary: close the frame only if a payload byte is pending
            if (hold_vld_q) begin
              emit_o      = 1'b1;
              emit_last_o = 1'b1;
              done_d      = 1'b1;
            end
            hold_vld_d = 1'b0;
          end else if (cls_i.is_esc) begin
            st_d = ST_ESC;
          end else begin
            push    = 1'b1;
            decoded = raw_i;
          end
        end
        ST_ESC: begin
          st_d = ST_PLAIN;
          if (cls_i.is_sep) begin
            // aborted frame: drop the pending byte, no completion
            err_d      = 1'b1;
            hold_vld_d = 1'b0;
          end else if (cls_i.is_code_sep) begin
            push    = 1'b1;
            decoded = sep_i;
          end else if (cls_i.is_code_esc) begin
            push    = 1'b1;
            decoded = esc_i;
          end else begin
            err_d = 1'b1;
          end
        end
        default: st_d = ST_PLAIN;
      endcase

      if (push) begin
        emit_o      = hold_vld_q;
        emit_last_o = 1'b0;
        hold_en     = 1'b1;
        hold_d      = decoded;
        hold_vld_d  = 1'b1;
      end
    end
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_PLAIN;
      hold_vld_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
      if (fire_i) begin
        st_q       <= st_d;
        hold_vld_q <= hold_vld_d;
      end
    end
  end

  // Payload holding register, no reset needed on the data path
  always_ff @(posedge clk_i) begin
    if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  // R9: an abort never coincides with a clean frame close
  p_err_excl_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_q && done_q));

  // R8: an accepted byte after an escape always leaves the escape state
  p_esc_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ESC && fire_i) |=> (st_q == ST_PLAIN));

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

endmodule

// File: rtl/sfd_out_stage.sv
module sfd_out_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          load_last_i,
  input  logic          out_ready_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_last_o,
  output logic          slot_free_o
);

  logic          vld_q, vld_d;
  logic [DW-1:0] data_q;
  logic          last_q;

  always_comb begin
    vld_d = vld_q;
    if (load_i) begin
      vld_d = 1'b1;
    end else if (out_ready_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      data_q <= load_data_i;
      last_q <= load_last_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = data_q;
  assign out_last_o  = last_q;
  assign slot_free_o = !vld_q || out_ready_i;

  // R11: a new byte is never loaded over one that is stalled
  p_no_overwrite_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!vld_q || out_ready_i));

  // R11: a stalled byte stays put
  p_stall_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !out_ready_i) |=> (vld_q && $stable(data_q) && $stable(last_q)));

endmodule

// File: rtl/sep_frame_decoder.sv
module sep_frame_decoder
  import sfd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] cfg_sep_i,
  input  logic [DW-1:0] cfg_esc_i,
  input  logic [DW-1:0] cfg_esc_sep_i,
  input  logic [DW-1:0] cfg_esc_esc_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_last_o,
  input  logic          out_ready_i,
  output logic          frame_done_o,
  output logic          proto_err_o
);

  byte_cls_t     cls;
  logic          fire;
  logic          slot_free;
  logic          emit;
  logic [DW-1:0] emit_data;
  logic          emit_last;

  assign in_ready_o = slot_free;
  assign fire       = in_valid_i && slot_free;

  sfd_classify #(.DW(DW)) u_classify (
    .raw_i      (in_data_i),
    .sep_i      (cfg_sep_i),
    .esc_i      (cfg_esc_i),
    .code_sep_i (cfg_esc_sep_i),
    .code_esc_i (cfg_esc_esc_i),
    .cls_o      (cls)
  );

  sfd_core #(.DW(DW)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .raw_i       (in_data_i),
    .cls_i       (cls),
    .sep_i       (cfg_sep_i),
    .esc_i       (cfg_esc_i),
    .emit_o      (emit),
    .emit_data_o (emit_data),
    .emit_last_o (emit_last),
    .done_o      (frame_done_o),
    .err_o       (proto_err_o)
  );

  sfd_out_stage #(.DW(DW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (emit),
    .load_data_i (emit_data),
    .load_last_i (emit_last),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o),
    .slot_free_o (slot_free)
  );

  // R7: the completion pulse coincides with a valid flagged final byte
  p_done_with_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (out_valid_o && out_last_o));

  // R11: backpressure stops intake
  p_ready_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

endmodule

// File: tb/sep_frame_decoder_tb_top.sv
`timescale 1ns/1ps
module sep_frame_decoder_tb_top;

  logic       clk;
  logic       rst_n;
  logic [7:0] c_sep, c_esc, c_csep, c_cesc;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic       out_ready;
  logic       done;
  logic       err;

  int unsigned tests;
  int unsigned fails;
  int unsigned cyc;

  logic [7:0] txb   [0:63];
  int         txn;
  logic [7:0] expd  [0:63];
  int         expn;
  logic [7:0] gotd  [0:63];
  logic       gotl  [0:63];
  int         gotn;
  int         done_cnt;
  int         err_cnt;
  logic       stall_en;
  logic [15:0] lfsr;
  logic       prev_stall;
  logic [7:0] prev_data;
  logic       prev_last;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  sep_frame_decoder #(.DW(8)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_sep_i     (c_sep),
    .cfg_esc_i     (c_esc),
    .cfg_esc_sep_i (c_csep),
    .cfg_esc_esc_i (c_cesc),
    .in_valid_i    (in_valid),
    .in_data_i     (in_data),
    .in_ready_o    (in_ready),
    .out_valid_o   (out_valid),
    .out_data_o    (out_data),
    .out_last_o    (out_last),
    .out_ready_i   (out_ready),
    .frame_done_o  (done),
    .proto_err_o   (err)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // downstream ready pattern, changed away from the sampling edge
  always @(posedge clk) begin
    #1;
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  // monitor on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid && out_data == prev_data && out_last == prev_last,
            "R11 stalled byte held", out_data, prev_data);
        chk(!in_ready || !(out_valid && !out_ready), "R11 intake blocked", in_ready, 0);
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
      if (out_valid && out_ready && gotn < 64) begin
        gotd[gotn] = out_data;
        gotl[gotn] = out_last;
        gotn++;
      end
      if (done) begin
        done_cnt++;
        chk(out_valid && out_last, "R7 done with flagged byte", {out_valid, out_last}, 3);
      end
      if (err) err_cnt++;
    end
  end

  // watchdog
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic tx_clear();
    txn = 0; expn = 0; gotn = 0; done_cnt = 0; err_cnt = 0;
  endtask

  task automatic tx_raw(input logic [7:0] b);
    txb[txn] = b; txn++;
  endtask

  // bench-side encoder and expected payload
  task automatic tx_pay(input logic [7:0] v);
    if (v == c_sep) begin
      tx_raw(c_esc); tx_raw(c_csep);
    end else if (v == c_esc) begin
      tx_raw(c_esc); tx_raw(c_cesc);
    end else begin
      tx_raw(v);
    end
    expd[expn] = v; expn++;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic r;
    r = 1'b0;
    in_valid = 1'b1;
    in_data  = b;
    while (!r) begin
      @(negedge clk);
      r = in_ready;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic run_check(input string req, input logic use_stall, input logic tail_last,
                           input int exp_done, input int exp_err);
    stall_en = use_stall;
    for (int i = 0; i < txn; i++) send_byte(txb[i]);
    stall_en = 1'b0;
    repeat (8) @(posedge clk);
    #1;
    chk(gotn == expn, {req, " byte count"}, gotn, expn);
    for (int i = 0; i < expn && i < gotn; i++) begin
      chk(gotd[i] == expd[i], {req, " R12 data order"}, gotd[i], expd[i]);
      chk(gotl[i] == ((i == expn - 1) ? tail_last : 1'b0), {req, " R6 end flag"},
          gotl[i], (i == expn - 1) ? tail_last : 1'b0);
    end
    chk(done_cnt == exp_done, {req, " R7 completion count"}, done_cnt, exp_done);
    chk(err_cnt == exp_err, {req, " error count"}, err_cnt, exp_err);
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 256; v++) begin
      tx_clear();
      tx_raw(c_sep);
      tx_pay(8'(v));
      tx_pay(8'(v) ^ 8'hFF);
      tx_raw(c_sep);
      run_check(req, v[0], 1'b1, 1, 0);
    end
  endtask

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    out_ready = 1'b1; stall_en = 1'b0; lfsr = 16'hACE1;
    prev_stall = 1'b0; prev_data = 8'h00; prev_last = 1'b0;
    c_sep = 8'hC0; c_esc = 8'hDB; c_csep = 8'hDD; c_cesc = 8'hDC;
    tx_clear();

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !done && !err && in_ready, "R1 in reset",
        {out_valid, done, err, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done && !err && in_ready, "R1 after release",
        {out_valid, done, err, in_ready}, 1);
    @(posedge clk);
    #1;

    // R2 R4 R5 R6: every byte value, escapes included
    sweep("R2/R4/R5 default cfg");

    // R3: separator runs and empty frames
    tx_clear();
    tx_raw(c_sep); tx_raw(c_sep); tx_raw(c_sep);
    tx_pay(8'h01); tx_pay(8'hC0); tx_pay(8'h03);
    tx_raw(c_sep); tx_raw(c_sep); tx_raw(c_sep); tx_raw(c_sep);
    tx_raw(c_sep); tx_raw(c_sep);
    run_check("R3 separator runs", 1'b1, 1'b1, 1, 0);

    // R8: bad second byte discards the pair, frame continues
    tx_clear();
    tx_raw(c_sep); tx_pay(8'h11);
    tx_raw(c_esc); tx_raw(8'h42);
    tx_pay(8'h22); tx_raw(c_sep);
    run_check("R8 bad escape", 1'b0, 1'b1, 1, 1);
    tx_clear();
    tx_raw(c_sep); tx_pay(8'h66);
    tx_raw(c_esc); tx_raw(c_esc);
    tx_pay(8'h77); tx_raw(c_sep);
    run_check("R8 double escape", 1'b1, 1'b1, 1, 1);

    // R9: separator inside an escape aborts, held byte dropped
    tx_clear();
    tx_raw(c_sep); tx_pay(8'h33); tx_raw(8'h44);
    tx_raw(c_esc); tx_raw(c_sep);
    run_check("R9 abort", 1'b0, 1'b0, 0, 1);
    tx_clear();
    tx_pay(8'h55); tx_raw(c_sep);
    run_check("R9 recovery frame", 1'b0, 1'b1, 1, 0);

    // R10: other character set
    c_sep = 8'h7E; c_esc = 8'h7D; c_csep = 8'h5E; c_cesc = 8'h5D;
    sweep("R10 alternate cfg");
    tx_clear();
    tx_raw(8'h7E); tx_pay(8'hC0); tx_pay(8'hDB); tx_raw(8'h7E);
    run_check("R10 old chars are data", 1'b0, 1'b1, 1, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule